// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two 32-bit operands over a series of clock cycles and delivers a 64-bit product. It keeps one 32-bit adder busy for the whole run. A 64-bit accumulator shifts one place to the right on every step. A separate multiplier register shifts right in step with it, and its lowest bit decides whether the stored multiplicand is added into the upper half of the accumulator. The carry out of that add goes into the top bit during the shift, so no sum bit is lost.

Signed products are formed in three stages. A front stage turns each negative operand into its magnitude; the most negative value becomes the unsigned magnitude 2^31. The unsigned loop then runs. A final stage negates the 64-bit result when exactly one operand was negative. A caller raises `start_i` for one cycle while the block is idle. `busy_o` stays high through the run, and `done_o` then pulses for one cycle with the product on `product_o`.

Top module: `smul_seq`

## Requirements
- R1: After reset, `busy_o` and `done_o` are 0 and `product_o` is all zeros.
- R2: With `signed_i` = 0, both operands are unsigned 32-bit values and `product_o` equals their full 64-bit unsigned product. This holds when the operands have their top bit set.
- R3: With `signed_i` = 1, both operands are two's complement values and `product_o` is their 64-bit two's complement product. This includes operands equal to 0x80000000 and products with a magnitude of 2^62.
- R4: `done_o` goes high exactly 33 clock cycles after the rising edge that accepts a start: 32 shift-add steps followed by one sign step. It stays high for exactly one cycle.
- R5: A start is accepted only when `busy_o` is 0. `busy_o` is 1 from the cycle after the accepting edge until the done cycle, and it is 0 whenever `done_o` is 1.
- R6: While `busy_o` is 1, `start_i`, `signed_i`, `a_i` and `b_i` have no effect. The product and done timing of the run in progress do not change.
- R7: `product_o` changes only in the cycle in which `done_o` is 1. Otherwise it holds its value.
- R8: A zero operand gives an all-zero product in both modes, whatever the sign of the other operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a multiply; sampled only when idle |
| signed_i | input | 1 | 1: two's complement operands, 0: unsigned |
| a_i | input | 32 | Multiplicand |
| b_i | input | 32 | Multiplier |
| busy_o | output | 1 | A multiply is in progress |
| done_o | output | 1 | One-cycle pulse: product_o holds a new result |
| product_o | output | 64 | Last completed product |

## Verification
The assertions assume that operands and mode are only meaningful on the edge where `start_i` meets an idle block. They capture exactly that triple and check the finished product against it. Both operands are allowed to change freely while the block is busy, and the stimulus uses this on purpose. It raises `start_i` and scrambles the operands in the middle of a run, so the latency and result checks also cover the rule that inputs are ignored while busy. Every new start is issued only when `busy_o` reads low, which includes the done cycle itself, so the done-cycle restart is covered without breaking the handshake.

// File: rtl/smul_pkg.sv
package smul_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_SIGN = 2'd2
    } smul_state_e;
endpackage

// File: rtl/smul_magnitude.sv
// Converts one operand to its unsigned magnitude and reports its sign.
module smul_magnitude #(
    parameter int W = 32
) (
    input  logic [W-1:0] val_i,
    input  logic         signed_en_i,
    output logic [W-1:0] mag_o,
    output logic         neg_o
);
    always_comb begin
        neg_o = signed_en_i & val_i[W-1];
        // the most negative value maps onto 2^(W-1) as an unsigned magnitude
        mag_o = neg_o ? ({W{1'b0}} - val_i) : val_i;
    end
endmodule

// File: rtl/smul_step.sv
// One shift-add iteration: conditional add into the upper half, then shift right.
module smul_step #(
    parameter int W = 32
) (
    input  logic [W-1:0]   mcand_i,
    input  logic           add_en_i,
    input  logic [2*W-1:0] prod_i,
    output logic [2*W-1:0] prod_o
);
    localparam int PW = 2 * W;

    logic [W:0]   sum;
    logic [W-1:0] addend;

    always_comb begin
        addend = add_en_i ? mcand_i : {W{1'b0}};
        sum    = {1'b0, prod_i[PW-1:W]} + {1'b0, addend};
        // carry bit lands in the top position of the shifted accumulator
        prod_o = {sum, prod_i[W-1:1]};
    end
endmodule

// File: rtl/smul_apply_sign.sv
// Negates the finished magnitude when the result must be negative.
module smul_apply_sign #(
    parameter int W = 32
) (
    input  logic [2*W-1:0] mag_i,
    input  logic           neg_i,
    output logic [2*W-1:0] res_o
);
    always_comb begin
        res_o = neg_i ? ({(2*W){1'b0}} - mag_i) : mag_i;
    end
endmodule

// File: rtl/smul_seq.sv
module smul_seq #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic           signed_i,
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    output logic           busy_o,
    output logic           done_o,
    output logic [2*W-1:0] product_o
);
    import smul_pkg::*;

    localparam int PW = 2 * W;
    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST_STEP = CW'(W - 1);

    typedef struct packed {
        smul_state_e    st;
        logic [CW-1:0]  cnt;
        logic [W-1:0]   mcand;
        logic [W-1:0]   mplier;
        logic [PW-1:0]  acc;
        logic           neg;
        logic [PW-1:0]  result;
        logic           done;
    } regs_t;

    regs_t r_q, r_d;

    // operand front end: index 0 is the multiplicand, 1 the multiplier
    logic [W-1:0] op_raw [2];
    logic [W-1:0] op_mag [2];
    logic         op_neg [2];

    assign op_raw[0] = a_i;
    assign op_raw[1] = b_i;

    for (genvar g = 0; g < 2; g++) begin : g_mag
        smul_magnitude #(.W(W)) mag_i (
            .val_i       (op_raw[g]),
            .signed_en_i (signed_i),
            .mag_o       (op_mag[g]),
            .neg_o       (op_neg[g])
        );
    end

    logic [PW-1:0] acc_step;
    logic [PW-1:0] signed_res;

    smul_step #(.W(W)) step_i (
        .mcand_i  (r_q.mcand),
        .add_en_i (r_q.mplier[0]),
        .prod_i   (r_q.acc),
        .prod_o   (acc_step)
    );

    smul_apply_sign #(.W(W)) sign_i (
        .mag_i (r_q.acc),
        .neg_i (r_q.neg),
        .res_o (signed_res)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st     = ST_RUN;
                    r_d.cnt    = '0;
                    r_d.mcand  = op_mag[0];
                    r_d.mplier = op_mag[1];
                    r_d.acc    = '0;
                    r_d.neg    = op_neg[0] ^ op_neg[1];
                end
            end
            ST_RUN: begin
                r_d.acc    = acc_step;
                r_d.mplier = r_q.mplier >> 1;
                r_d.cnt    = r_q.cnt + 1'b1;
                if (r_q.cnt == LAST_STEP) begin
                    r_d.st = ST_SIGN;
                end
            end
            ST_SIGN: begin
                r_d.result = signed_res;
                r_d.done   = 1'b1;
                r_d.st     = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, cnt: '0, mcand: '0, mplier: '0,
                     acc: '0, neg: 1'b0, result: '0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o    = (r_q.st != ST_IDLE);
    assign done_o    = r_q.done;
    assign product_o = r_q.result;
endmodule

// File: rtl/smul_seq_chk.sv
module smul_seq_chk #(
    parameter int W = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start_i,
    input logic           signed_i,
    input logic [W-1:0]   a_i,
    input logic [W-1:0]   b_i,
    input logic           busy_o,
    input logic           done_o,
    input logic [2*W-1:0] product_o
);
    localparam int PW = 2 * W;
    localparam int LW = $clog2(W + 2) + 1;

    logic [LW-1:0] lat_q;
    logic [W-1:0]  ca_q, cb_q;
    logic          cs_q;
    logic [PW-1:0] ref_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q <= '0;
            ca_q  <= '0;
            cb_q  <= '0;
            cs_q  <= 1'b0;
        end else begin
            lat_q <= busy_o ? lat_q + 1'b1 : '0;
            if (start_i && !busy_o) begin
                ca_q <= a_i;
                cb_q <= b_i;
                cs_q <= signed_i;
            end
        end
    end

    always_comb begin
        if (cs_q) ref_p = PW'($signed({{W{ca_q[W-1]}}, ca_q}) * $signed({{W{cb_q[W-1]}}, cb_q}));
        else      ref_p = PW'({{W{1'b0}}, ca_q} * {{W{1'b0}}, cb_q});
    end

    AST_UNSIGNED_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !cs_q |-> product_o == ref_p); // R2
    AST_SIGNED_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && cs_q |-> product_o == ref_p); // R3
    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> lat_q == LW'(W + 1)); // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R4
    AST_START_TO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !busy_o |=> busy_o); // R5
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o && $past(busy_o)); // R5
    AST_PRODUCT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(product_o)); // R7
endmodule

bind smul_seq smul_seq_chk #(.W(W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .signed_i  (signed_i),
    .a_i       (a_i),
    .b_i       (b_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .product_o (product_o)
);

// File: tb/smul_seq_tb_top.sv
module smul_seq_tb_top;
    localparam int W = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          signed_i = 1'b0;
    logic [W-1:0]  a_i = '0;
    logic [W-1:0]  b_i = '0;
    logic          busy_o, done_o;
    logic [63:0]   product_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [63:0] prod;
        int          due;
        string       req;
    } exp_t;

    exp_t sb[$];

    always #2 clk = ~clk;   // 250 MHz
    always @(posedge clk) cyc <= cyc + 1;

    smul_seq #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .signed_i(signed_i),
        .a_i(a_i), .b_i(b_i), .busy_o(busy_o), .done_o(done_o), .product_o(product_o)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_mul(input logic [31:0] a, input logic [31:0] b, input bit s);
        longint sa, sb2;
        if (s) begin
            sa  = longint'($signed(a));
            sb2 = longint'($signed(b));
            return 64'(sa * sb2);
        end
        return {32'd0, a} * {32'd0, b};
    endfunction

    // driver: issue one multiply; optionally disturb inputs during the run
    task automatic drive(input logic [31:0] a, input logic [31:0] b, input bit s,
                         input string req, input bit poke);
        exp_t e;
        @(negedge clk);
        while (busy_o) @(negedge clk);
        start_i  = 1'b1;
        signed_i = s;
        a_i      = a;
        b_i      = b;
        e.prod   = ref_mul(a, b, s);
        e.due    = cyc + 1 + 33;
        e.req    = req;
        sb.push_back(e);
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, "R5 busy after accept", 64'(busy_o), 64'd1);
        if (poke) begin
            // R6: start and operand changes while busy must not matter
            repeat (5) begin
                @(negedge clk);
                start_i  = 1'b1;
                signed_i = ~s;
                a_i      = $urandom;
                b_i      = $urandom;
            end
            @(negedge clk);
            start_i = 1'b0;
        end
    endtask

    // monitor: compare results and hold behaviour
    logic [63:0] last_prod = '0;
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (done_o) begin
                    if (sb.size() == 0) begin
                        check(1'b0, "R5 unexpected done", 64'd1, 64'd0);
                    end else begin
                        exp_t e;
                        e = sb.pop_front();
                        check(product_o == e.prod, e.req, product_o, e.prod);
                        check(cyc == e.due, "R4 done latency", 64'(cyc), 64'(e.due));
                        check(busy_o == 1'b0, "R5 busy low at done", 64'(busy_o), 64'd0);
                    end
                end else if (product_o != last_prod) begin
                    check(1'b0, "R7 product changed without done", product_o, last_prod);
                end
                if (done_o) begin
                    @(negedge clk);
                    check(done_o == 1'b0, "R4 done single cycle", 64'(done_o), 64'd0);
                    if (done_o) continue;
                end
                last_prod = product_o;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(busy_o == 1'b0 && done_o == 1'b0 && product_o == 64'd0, "R1 reset state",
              {62'd0, busy_o, done_o} | product_o, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        drive(32'd3, 32'd7, 1'b0, "R2 small unsigned", 1'b0);
        drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R2 max unsigned", 1'b0);
        drive(32'h8000_0000, 32'd2, 1'b0, "R2 top bit unsigned", 1'b0);
        drive(32'hDEAD_BEEF, 32'h1234_5678, 1'b0, "R2 mixed unsigned", 1'b0);
        drive(-32'sd5, 32'd6, 1'b1, "R3 neg times pos", 1'b0);
        drive(-32'sd9, -32'sd11, 1'b1, "R3 neg times neg", 1'b0);
        drive(32'h8000_0000, 32'h8000_0000, 1'b1, "R3 most negative squared", 1'b0);
        drive(32'h8000_0000, 32'd1, 1'b1, "R3 most negative times one", 1'b0);
        drive(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, "R3 most negative times minus one", 1'b0);
        drive(32'd0, 32'h8000_0000, 1'b1, "R8 zero times negative", 1'b0);
        drive(32'hFFFF_FFFF, 32'd0, 1'b0, "R8 max times zero unsigned", 1'b0);
        drive(32'd12345, -32'sd678, 1'b1, "R6 signed with inputs disturbed", 1'b1);
        drive(32'hCAFE_F00D, 32'h0BAD_F00D, 1'b0, "R6 unsigned with inputs disturbed", 1'b1);
        for (int i = 0; i < 20; i++) begin
            drive($urandom, $urandom, i[0], "R3 random operands", 1'b0);
        end

        while (sb.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule